// File: doc/BRIEF.md
# GPIO Input Capture and Interrupt Conditioning

This block sits between the general-purpose pins of a chip and its control logic. It takes an external interrupt pin, brings it into the core clock domain, optionally inverts it, and turns it into an interrupt status bit. That bit either follows the conditioned level or records a rising edge in a sticky flag that software clears by writing a one. It also latches an external general-purpose input bus when an external write strobe makes its selected transition. Each capture gives a held data word and a one-cycle valid pulse.

A small decoder turns a 2-bit port mode field and a clock-pin direction bit into output enables for the data bus and the pixel clock pin. It also produces a select that routes the clock pin in as the pixel clock. The control inputs come from a register that resets to zero. All outputs are registered.

Top module: `gpio_capture_ctl`

## Requirements
- R1: While `rst` is high, every output of the block is 0.
- R2: When `irq_edge_mode` is 0, `irq_status` equals `irq_pin` XOR `irq_invert`. It follows a pin change after three clock edges: two synchronizer stages and one output register.
- R3: Inversion is applied to the synchronized pin before edge detection. With `irq_invert` at 1, a falling pin transition counts as a rising edge, and a rising pin transition does not.
- R4: When `irq_edge_mode` is 1, a rising edge of the conditioned interrupt sets `irq_status`. The bit then stays set after the pin returns low, for as long as `irq_clear` is 0.
- R5: In edge mode, a cycle with `irq_clear` high clears `irq_status` on the next edge, unless a new conditioned rising edge arrives in that cycle. In level mode `irq_clear` has no effect.
- R6: `irq_rise` is high for exactly one cycle for each rising edge of the conditioned interrupt. The pulse comes on the same edge at which the edge-mode status is set.
- R7: When `cap_falling` is 0, a low-to-high transition of `strobe_pin` captures `gp_in`. The captured value appears on `cap_data` three clock edges after the transition, and `cap_valid` is high for that one cycle. `gp_in` is sampled at the same time as the strobe.
- R8: When `cap_falling` is 1, only high-to-low strobe transitions capture. In either setting, a strobe transition of the other polarity leaves `cap_data` unchanged and `cap_valid` low.
- R9: `cap_data` keeps its value between captures, whatever happens on `gp_in`.
- R10: One clock edge after `port_mode` is applied, `data_oe` takes the value that mode selects. Mode 2'b00 (normal port) gives `gp_dir`, 2'b01 (pixel output) gives all ones, 2'b10 (pixel input) gives all zeros, and 2'b11 (reserved) gives all zeros.
- R11: One clock edge after its inputs, `pclk_oe` equals `clk_mode`. `pclk_in_sel` is 1 only when `clk_mode` is 0 and `port_mode` is 2'b10, and it is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pin | input | 1 | Asynchronous external interrupt pin |
| irq_invert | input | 1 | 1 inverts the interrupt pin after synchronization |
| irq_edge_mode | input | 1 | 0 selects level status, 1 selects sticky rising-edge status |
| irq_clear | input | 1 | Write-one-to-clear for the sticky status |
| irq_status | output | 1 | Interrupt status bit |
| irq_rise | output | 1 | One-cycle pulse on each conditioned rising edge |
| strobe_pin | input | 1 | Asynchronous external write strobe |
| cap_falling | input | 1 | 0 captures on strobe rise, 1 captures on strobe fall |
| gp_in | input | DATA_W | General-purpose input bus |
| cap_data | output | DATA_W | Last captured input word |
| cap_valid | output | 1 | One-cycle pulse when `cap_data` is updated |
| port_mode | input | 2 | Port mode field |
| clk_mode | input | 1 | 1 drives the pixel clock out on the clock pin |
| gp_dir | input | DATA_W | Per-bit output enable used in normal port mode |
| data_oe | output | DATA_W | Data bus output enables |
| pclk_oe | output | 1 | Clock pin output enable |
| pclk_in_sel | output | 1 | Selects the clock pin as the incoming pixel clock |

## Verification
A stuck or mistimed synchronizer stage shows up as status or capture outputs that arrive a cycle early or late against the fixed three-edge latency, and this is visible on the first pin or strobe transition. A wrong edge-history register either drops a sticky set or fires `irq_rise` or `cap_valid` on the wrong polarity or for more than one cycle. This shows within three cycles of the offending transition. A wrong mode decode or a lost captured word appears on `data_oe`, `pclk_in_sel` or `cap_data` one edge after the input that selects it.

// File: rtl/gpc_pkg.sv
package gpc_pkg;

  typedef enum logic [1:0] {
    PM_GPIO    = 2'b00,
    PM_PIX_OUT = 2'b01,
    PM_PIX_IN  = 2'b10,
    PM_RSVD    = 2'b11
  } port_mode_e;

endpackage

// File: rtl/gpc_sync.sv
module gpc_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= '0;
    else     stage[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[s] <= '0;
      else     stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];

endmodule

// File: rtl/gpc_irq_cond.sv
module gpc_irq_cond (
  input  logic clk,
  input  logic rst,
  input  logic lvl_sync,
  input  logic invert,
  input  logic edge_mode,
  input  logic clear,
  output logic status,
  output logic rise
);

  logic cond;
  logic cond_q;
  logic rise_c;

  assign cond   = lvl_sync ^ invert;
  assign rise_c = cond & ~cond_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cond_q <= 1'b0;
      rise   <= 1'b0;
      status <= 1'b0;
    end else begin
      cond_q <= cond;
      rise   <= rise_c;
      if (!edge_mode) status <= cond;
      else            status <= rise_c | (status & ~clear);
    end
  end

endmodule

// File: rtl/gpc_capture.sv
module gpc_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe_sync,
  input  logic [DATA_W-1:0] data_sync,
  input  logic              falling_sel,
  output logic [DATA_W-1:0] cap_data,
  output logic              cap_valid
);

  logic strobe_q;
  logic hit;

  always_comb begin
    if (falling_sel) hit = ~strobe_sync & strobe_q;
    else             hit = strobe_sync & ~strobe_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q  <= 1'b0;
      cap_valid <= 1'b0;
      cap_data  <= '0;
    end else begin
      strobe_q  <= strobe_sync;
      cap_valid <= hit;
      if (hit) cap_data <= data_sync;
    end
  end

endmodule

// File: rtl/gpc_mode_dec.sv
module gpc_mode_dec
  import gpc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        port_mode,
  input  logic              clk_mode,
  input  logic [DATA_W-1:0] gp_dir,
  output logic [DATA_W-1:0] data_oe,
  output logic              pclk_oe,
  output logic              pclk_in_sel
);

  port_mode_e       mode;
  logic [DATA_W-1:0] oe_c;

  assign mode = port_mode_e'(port_mode);

  always_comb begin
    unique case (mode)
      PM_GPIO:    oe_c = gp_dir;
      PM_PIX_OUT: oe_c = '1;
      PM_PIX_IN:  oe_c = '0;
      default:    oe_c = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_oe     <= '0;
      pclk_oe     <= 1'b0;
      pclk_in_sel <= 1'b0;
    end else begin
      data_oe     <= oe_c;
      pclk_oe     <= clk_mode;
      pclk_in_sel <= ~clk_mode & (mode == PM_PIX_IN);
    end
  end

endmodule

// File: rtl/gpio_capture_ctl.sv
module gpio_capture_ctl #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_pin,
  input  logic              irq_invert,
  input  logic              irq_edge_mode,
  input  logic              irq_clear,
  output logic              irq_status,
  output logic              irq_rise,
  input  logic              strobe_pin,
  input  logic              cap_falling,
  input  logic [DATA_W-1:0] gp_in,
  output logic [DATA_W-1:0] cap_data,
  output logic              cap_valid,
  input  logic [1:0]        port_mode,
  input  logic              clk_mode,
  input  logic [DATA_W-1:0] gp_dir,
  output logic [DATA_W-1:0] data_oe,
  output logic              pclk_oe,
  output logic              pclk_in_sel
);

  localparam int CAP_W = DATA_W + 1;

  logic             irq_sync_lvl;
  logic [CAP_W-1:0] cap_sync;

  gpc_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_irq_sync (
    .clk (clk),
    .rst (rst),
    .d   (irq_pin),
    .q   (irq_sync_lvl)
  );

  gpc_sync #(.WIDTH(CAP_W), .STAGES(SYNC_STAGES)) u_cap_sync (
    .clk (clk),
    .rst (rst),
    .d   ({strobe_pin, gp_in}),
    .q   (cap_sync)
  );

  gpc_irq_cond u_irq (
    .clk       (clk),
    .rst       (rst),
    .lvl_sync  (irq_sync_lvl),
    .invert    (irq_invert),
    .edge_mode (irq_edge_mode),
    .clear     (irq_clear),
    .status    (irq_status),
    .rise      (irq_rise)
  );

  gpc_capture #(.DATA_W(DATA_W)) u_cap (
    .clk         (clk),
    .rst         (rst),
    .strobe_sync (cap_sync[CAP_W-1]),
    .data_sync   (cap_sync[DATA_W-1:0]),
    .falling_sel (cap_falling),
    .cap_data    (cap_data),
    .cap_valid   (cap_valid)
  );

  gpc_mode_dec #(.DATA_W(DATA_W)) u_dec (
    .clk         (clk),
    .rst         (rst),
    .port_mode   (port_mode),
    .clk_mode    (clk_mode),
    .gp_dir      (gp_dir),
    .data_oe     (data_oe),
    .pclk_oe     (pclk_oe),
    .pclk_in_sel (pclk_in_sel)
  );

endmodule

// File: rtl/gpc_checker.sv
module gpc_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              irq_invert,
  input logic              irq_edge_mode,
  input logic              irq_clear,
  input logic              irq_sync_lvl,
  input logic              irq_status,
  input logic              irq_rise,
  input logic [DATA_W-1:0] cap_data,
  input logic              cap_valid,
  input logic [1:0]        port_mode,
  input logic              clk_mode,
  input logic [DATA_W-1:0] data_oe,
  input logic              pclk_oe,
  input logic              pclk_in_sel
);

  logic past_ok;

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!irq_status && !irq_rise && !cap_valid && cap_data == '0 &&
             data_oe == '0 && !pclk_oe && !pclk_in_sel));

  a_r2_level_follows: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(irq_edge_mode)) |->
      (irq_status == ($past(irq_sync_lvl) ^ $past(irq_invert))));

  a_r4_sticky_hold: assert property (@(posedge clk) disable iff (rst)
    (irq_edge_mode && irq_status && !irq_clear) |=> irq_status);

  a_r5_clear_unless_rise: assert property (@(posedge clk) disable iff (rst)
    (irq_edge_mode && irq_clear) |=> (irq_status == irq_rise));

  a_r6_rise_single: assert property (@(posedge clk) disable iff (rst)
    irq_rise |=> !irq_rise);

  a_r9_data_hold: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !cap_valid) |-> $stable(cap_data));

  a_r10_reserved_off: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(port_mode) == 2'b11) |-> (data_oe == '0));

  a_r10_pixout_on: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(port_mode) == 2'b01) |-> (data_oe == '1));

  a_r11_clk_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(pclk_oe && pclk_in_sel));

  a_r11_clk_drive: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (pclk_oe == $past(clk_mode)));

endmodule

bind gpio_capture_ctl gpc_checker #(.DATA_W(DATA_W)) u_gpc_checker (
  .clk           (clk),
  .rst           (rst),
  .irq_invert    (irq_invert),
  .irq_edge_mode (irq_edge_mode),
  .irq_clear     (irq_clear),
  .irq_sync_lvl  (irq_sync_lvl),
  .irq_status    (irq_status),
  .irq_rise      (irq_rise),
  .cap_data      (cap_data),
  .cap_valid     (cap_valid),
  .port_mode     (port_mode),
  .clk_mode      (clk_mode),
  .data_oe       (data_oe),
  .pclk_oe       (pclk_oe),
  .pclk_in_sel   (pclk_in_sel)
);

// File: tb/tb_gpio_capture_ctl.sv
`timescale 1ns/1ps
module tb_gpio_capture_ctl;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic         irq_pin, irq_invert, irq_edge_mode, irq_clear;
  logic         irq_status, irq_rise;
  logic         strobe_pin, cap_falling;
  logic [W-1:0] gp_in, cap_data, gp_dir, data_oe;
  logic         cap_valid;
  logic [1:0]   port_mode;
  logic         clk_mode, pclk_oe, pclk_in_sel;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  gpio_capture_ctl #(.DATA_W(W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst),
    .irq_pin(irq_pin), .irq_invert(irq_invert), .irq_edge_mode(irq_edge_mode),
    .irq_clear(irq_clear), .irq_status(irq_status), .irq_rise(irq_rise),
    .strobe_pin(strobe_pin), .cap_falling(cap_falling), .gp_in(gp_in),
    .cap_data(cap_data), .cap_valid(cap_valid),
    .port_mode(port_mode), .clk_mode(clk_mode), .gp_dir(gp_dir),
    .data_oe(data_oe), .pclk_oe(pclk_oe), .pclk_in_sel(pclk_in_sel)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_oe(input logic [1:0] pm, input logic [W-1:0] dir);
    case (pm)
      2'b00:   return dir;
      2'b01:   return '1;
      default: return '0;
    endcase
  endfunction

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; irq_pin = 0; irq_invert = 0; irq_edge_mode = 0; irq_clear = 0;
    strobe_pin = 0; cap_falling = 0; gp_in = '0; port_mode = 2'b00;
    clk_mode = 0; gp_dir = '0;
    step(3);
    // R1 reset state
    check("R1 status", irq_status, 0);
    check("R1 rise", irq_rise, 0);
    check("R1 cap", {cap_valid, cap_data}, 0);
    check("R1 dec", {data_oe, pclk_oe, pclk_in_sel}, 0);
    rst = 1'b0;
    step(4);

    // R2 level mode sweep over invert and pin
    for (int i = 0; i < 2; i++) begin
      for (int p = 0; p < 2; p++) begin
        irq_invert = i[0]; irq_pin = p[0];
        step(2);
        check("R2 latency", irq_status, 32'(p[0] ^ i[0] ^ 1'b1) & 32'(irq_status));
        step(1);
        check("R2 level", irq_status, 32'(p[0] ^ i[0]));
      end
    end
    // R5 clear ignored in level mode (condition currently 1 from pin=1,inv=1? set explicitly)
    irq_invert = 0; irq_pin = 1; step(4);
    irq_clear = 1; step(1); irq_clear = 0;
    check("R5 level ignores clear", irq_status, 1);

    // R4/R6 edge mode rise sets sticky status
    irq_pin = 0; step(4);
    irq_edge_mode = 1; irq_clear = 1; step(1); irq_clear = 0;
    check("R5 clear", irq_status, 0);
    irq_pin = 1; step(2);
    check("R6 not yet", irq_rise, 0);
    step(1);
    check("R6 rise pulse", irq_rise, 1);
    check("R4 set", irq_status, 1);
    step(1);
    check("R6 one cycle", irq_rise, 0);
    irq_pin = 0; step(5);
    check("R4 sticky", irq_status, 1);
    check("R6 no pulse on fall", irq_rise, 0);
    irq_clear = 1; step(1); irq_clear = 0;
    check("R5 clear edge", irq_status, 0);

    // R3 inversion before edge detect
    irq_invert = 1; irq_pin = 1; step(4);
    irq_clear = 1; step(1); irq_clear = 0;
    check("R3 settle", irq_status, 0);
    irq_pin = 0; step(3);
    check("R3 fall counts as rise", irq_status, 1);
    check("R3 rise pulse", irq_rise, 1);
    irq_clear = 1; step(1); irq_clear = 0;
    irq_pin = 1; step(4);
    check("R3 pin rise ignored", irq_status, 0);
    irq_invert = 0; irq_edge_mode = 0; irq_pin = 0; step(4);

    // R7/R8/R9 capture sweep for both strobe polarities
    for (int f = 0; f < 2; f++) begin
      cap_falling = f[0];
      strobe_pin = f[0]; step(4);
      for (int v = 0; v < 16; v++) begin
        logic [W-1:0] val;
        logic [W-1:0] other;
        val   = W'((v * 37) ^ 8'h5A ^ (f * 8'hC3));
        other = ~val;
        gp_in = val; strobe_pin = ~f[0];
        step(2);
        check(f ? "R8 early" : "R7 early", cap_valid, 0);
        step(1);
        check(f ? "R8 valid" : "R7 valid", cap_valid, 1);
        check(f ? "R8 data" : "R7 data", cap_data, 32'(val));
        step(1);
        check(f ? "R8 valid one cycle" : "R7 valid one cycle", cap_valid, 0);
        gp_in = other; step(2);
        check("R9 hold", cap_data, 32'(val));
        strobe_pin = f[0]; step(3);
        check("R8 wrong edge no valid", cap_valid, 0);
        check("R8 wrong edge no data", cap_data, 32'(val));
      end
    end

    // R10/R11 exhaustive mode decode sweep
    for (int pm = 0; pm < 4; pm++) begin
      for (int cm = 0; cm < 2; cm++) begin
        for (int d = 0; d < 4; d++) begin
          logic [W-1:0] dir;
          dir = W'(d * 8'h5B);
          port_mode = pm[1:0]; clk_mode = cm[0]; gp_dir = dir;
          step(1);
          check("R10 data_oe", data_oe, 32'(exp_oe(pm[1:0], dir)));
          check("R11 pclk_oe", pclk_oe, 32'(cm[0]));
          check("R11 pclk_in_sel", pclk_in_sel, 32'((cm == 0) && (pm == 2)));
        end
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule